// File: doc/BRIEF.md
# Reciprocal-Iteration Integer Divider

This block divides a 16-bit unsigned dividend by a 16-bit unsigned divisor that changes at run time. It has no subtract-and-shift loop. It first shifts the divisor left until its top bit is set, which gives a fixed-point value in [0.5, 1). From that value it forms a linear first guess of the reciprocal, 2.9142 minus twice the normalised divisor. Four Newton-Raphson steps, each `q' = q * (2 - d*q)`, then refine the guess. The refined reciprocal is multiplied by the dividend and shifted back by the saved normalisation amount. A remainder check nudges the result by at most one unit, so the answer is the exact integer floor.

One multiplier is shared by every product. A small controller walks through capture, normalise, refine, scale, correct and report. Software issues a one-cycle `start` with both operands. It then waits for the one-cycle `done` pulse and reads `quotient`, which holds until the next accepted start. A zero divisor bypasses the arithmetic and raises `div_zero`.

Top module: `nr_recip_div`

## Requirements
- R1: After reset, `done` is 0, `quotient` is 0 and `div_zero` is 0.
- R2: When a `start` with a nonzero divisor is sampled in idle, `done` goes high exactly 12 clock cycles after that sampling edge and stays high for one cycle only.
- R3: For any nonzero divisor, `quotient` at `done` equals floor(dividend / divisor).
- R4: With divisor 1, `quotient` equals the dividend for all dividend values, including 0 and 65535.
- R5: With the dividend equal to the divisor, `quotient` is 1. With the dividend below the divisor, it is 0.
- R6: At the range extremes, 65535/65535 gives 1, 65535/1 gives 65535, 0/65535 gives 0 and 65535/32768 gives 1.
- R7: A zero divisor makes `done` rise one cycle after `start` is sampled, with `quotient` = 16'hFFFF and `div_zero` = 1.
- R8: `div_zero` is 0 at `done` for every nonzero divisor, including the first operation after a zero-divisor one.
- R9: A `start` asserted while an operation is in progress is ignored. The running result is unaffected, and no extra `done` follows.
- R10: After `done`, `quotient` and `div_zero` keep their values, and `done` stays low, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only when idle |
| dividend | input | 16 | Unsigned numerator, captured with `start` |
| divisor | input | 16 | Unsigned denominator, captured with `start` |
| quotient | output | 16 | Floor of dividend / divisor, or all ones on zero divisor |
| done | output | 1 | One-cycle pulse when `quotient` is valid |
| div_zero | output | 1 | Set with `done` when the divisor was zero |

## Verification
The failure modes are all internal: a wrong normalisation shift, a poor seed, a truncated refinement step or a skipped correction. None of them is visible until the pulse at cycle 12. At that point each shows up as a quotient off by one or by a power of two, most often when the divisor sits at a power-of-two boundary or the quotient is an exact integer. For that reason, every result is compared against the integer floor, and the corner operands sit right on those boundaries. A miscounted refinement loop or a controller that does not ignore a start while busy shows up instead as a `done` in the wrong cycle, or as a second pulse. The bench counts cycles from the start strobe to catch this.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_NORM = 3'd1,
        ST_ITER = 3'd2,
        ST_MULQ = 3'd3,
        ST_FIX  = 3'd4,
        ST_DONE = 3'd5
    } div_state_e;

endpackage

// File: rtl/nr_div_lzc.sv
module nr_div_lzc #(
    parameter int W  = 16,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);

    // Highest set bit wins; the result is unused when vec is zero.
    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                zeros = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/nr_div_mul.sv
module nr_div_mul #(
    parameter int W = 38
) (
    input  logic [W-1:0]   op_x,
    input  logic [W-1:0]   op_y,
    output logic [2*W-1:0] prod
);

    assign prod = {{W{1'b0}}, op_x} * {{W{1'b0}}, op_y};

endmodule

// File: rtl/nr_recip_div.sv
module nr_recip_div #(
    parameter int DW    = 16,
    parameter int FRAC  = 36,
    parameter int ITERS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic          done,
    output logic          div_zero
);
    import nr_div_pkg::*;

    localparam int MW  = FRAC + 2;           // Q2.FRAC reciprocal width
    localparam int PW  = 2 * MW;             // shared product width
    localparam int LZW = $clog2(DW);
    localparam int CNW = $clog2(ITERS) + 1;
    localparam int SHW = $clog2(PW + 1);
    localparam int RW  = 2 * DW + 3;         // signed remainder width
    localparam int XW  = 2 * DW + 2;         // width for assertion products
    localparam logic [MW-1:0] TWO    = {2'b10, {FRAC{1'b0}}};
    localparam logic [MW-1:0] SEED_K = MW'((64'd29142 << FRAC) / 64'd10000);

    typedef struct packed {
        div_state_e     st;
        logic           phase;
        logic [CNW-1:0] cnt;
        logic [DW-1:0]  a;
        logic [DW-1:0]  b;
        logic [LZW-1:0] lz;
        logic [MW-1:0]  dq;
        logic [MW-1:0]  q;
        logic [MW-1:0]  e;
        logic [DW:0]    quot;
        logic           err;
    } div_regs_t;

    div_regs_t      s_d, s_q;
    logic [LZW-1:0] lz_w;
    logic [DW-1:0]  b_norm;
    logic [MW-1:0]  mul_x, mul_y, two_minus_e, prod_hi;
    logic [PW-1:0]  prod;
    logic [SHW-1:0] sh_w;
    logic [RW-1:0]  rem;

    nr_div_lzc #(.W(DW), .CW(LZW)) lzc_i (.vec(s_q.b), .zeros(lz_w));
    nr_div_mul #(.W(MW)) mul_i (.op_x(mul_x), .op_y(mul_y), .prod(prod));

    assign b_norm      = s_q.b << lz_w;
    assign two_minus_e = TWO - s_q.e;
    assign prod_hi     = MW'(prod >> FRAC);
    assign sh_w        = SHW'(FRAC + DW) - SHW'(s_q.lz);
    assign rem         = RW'(s_q.a) - RW'(prod);

    // Operand routing for the single multiplier
    always_comb begin
        mul_x = '0;
        mul_y = '0;
        case (s_q.st)
            ST_ITER: begin
                mul_x = s_q.q;
                mul_y = s_q.phase ? two_minus_e : s_q.dq;
            end
            ST_MULQ: begin
                mul_x = s_q.q;
                mul_y = MW'(s_q.a);
            end
            ST_FIX: begin
                mul_x = MW'(s_q.quot);
                mul_y = MW'(s_q.b);
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.a   = dividend;
                    s_d.b   = divisor;
                    s_d.err = 1'b0;
                    if (divisor == '0) begin
                        s_d.quot = {1'b0, {DW{1'b1}}};
                        s_d.err  = 1'b1;
                        s_d.st   = ST_DONE;
                    end else begin
                        s_d.st = ST_NORM;
                    end
                end
            end
            ST_NORM: begin
                s_d.lz    = lz_w;
                s_d.dq    = MW'(b_norm) << (FRAC - DW);
                s_d.q     = SEED_K - (s_d.dq << 1);
                s_d.cnt   = '0;
                s_d.phase = 1'b0;
                s_d.st    = ST_ITER;
            end
            ST_ITER: begin
                if (!s_q.phase) begin
                    s_d.e     = prod_hi;
                    s_d.phase = 1'b1;
                end else begin
                    s_d.q     = prod_hi;
                    s_d.phase = 1'b0;
                    s_d.cnt   = s_q.cnt + 1'b1;
                    if (s_q.cnt == CNW'(ITERS - 1)) begin
                        s_d.st = ST_MULQ;
                    end
                end
            end
            ST_MULQ: begin
                s_d.quot = (DW+1)'(prod >> sh_w);
                s_d.st   = ST_FIX;
            end
            ST_FIX: begin
                if (rem[RW-1]) begin
                    s_d.quot = s_q.quot - 1'b1;
                end else if (rem >= RW'(s_q.b)) begin
                    s_d.quot = s_q.quot + 1'b1;
                end
                s_d.st = ST_DONE;
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign quotient = s_q.quot[DW-1:0];
    assign done     = (s_q.st == ST_DONE);
    assign div_zero = s_q.err;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_ZERO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == {DW{1'b1}})); // R7
    AST_FLOOR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (XW'(quotient) * XW'(s_q.b) <= XW'(s_q.a))); // R3
    AST_FLOOR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> ((XW'(quotient) + 1'b1) * XW'(s_q.b) > XW'(s_q.a))); // R3
    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ITER || s_q.st == ST_MULQ || s_q.st == ST_FIX)
        |-> ($stable(s_q.a) && $stable(s_q.b))); // R9
    AST_NORM_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ITER) |-> s_q.dq[FRAC-1]); // R3

endmodule

// File: tb/nr_recip_div_tb_top.sv
module nr_recip_div_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [15:0] quotient;
    logic        done;
    logic        div_zero;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    nr_recip_div dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .quotient(quotient), .done(done), .div_zero(div_zero)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue one operation, return observed latency in cycles
    task automatic run_op(input logic [15:0] a, input logic [15:0] b, output int lat);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic div_check(input string req, input logic [15:0] a, input logic [15:0] b);
        int lat;
        run_op(a, b, lat);
        check(req, longint'(quotient), longint'(a / b));
        check({req, " R8 flag"}, longint'(div_zero), 0);
    endtask

    task automatic t_reset;
        check("R1 done", longint'(done), 0);
        check("R1 quotient", longint'(quotient), 0);
        check("R1 div_zero", longint'(div_zero), 0);
    endtask

    task automatic t_latency;
        int lat;
        run_op(16'd1000, 16'd7, lat);
        check("R2 latency", lat, 12);
        check("R3 value", longint'(quotient), 142);
        @(negedge clk);
        check("R2 single pulse", longint'(done), 0);
    endtask

    task automatic t_corners;
        div_check("R4 one", 16'd0, 16'd1);
        div_check("R4 one", 16'd12345, 16'd1);
        div_check("R4 one", 16'hFFFF, 16'd1);
        div_check("R5 equal", 16'd977, 16'd977);
        div_check("R5 less", 16'd976, 16'd977);
        div_check("R5 equal", 16'd1, 16'd1);
        div_check("R6 max", 16'hFFFF, 16'hFFFF);
        div_check("R6 max", 16'd0, 16'hFFFF);
        div_check("R6 max", 16'hFFFF, 16'h8000);
        div_check("R6 max", 16'hFFFF, 16'h7FFF);
        div_check("R3 exact", 16'd60000, 16'd3);
        div_check("R3 exact", 16'd65534, 16'd2);
        div_check("R3 pow2", 16'd4096, 16'd4096);
        div_check("R3 pow2", 16'd4095, 16'd64);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a, b;
            a = 16'($urandom);
            b = 16'($urandom) >> ($urandom % 16);
            if (b == '0) b = 16'd3;
            div_check("R3 random", a, b);
        end
    endtask

    task automatic t_zero;
        int lat;
        run_op(16'd555, 16'd0, lat);
        check("R7 latency", lat, 1);
        check("R7 quotient", longint'(quotient), 65535);
        check("R7 flag", longint'(div_zero), 1);
        div_check("R8 after zero", 16'd555, 16'd5);
    endtask

    task automatic t_busy;
        int lat;
        @(negedge clk);
        dividend = 16'd50000;
        divisor  = 16'd9;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        dividend = 16'd10;
        divisor  = 16'd0;
        start    = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R9 latency", lat, 12);
        check("R9 quotient", longint'(quotient), 5555);
        check("R9 flag", longint'(div_zero), 0);
        begin
            int extra = 0;
            repeat (20) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R9 no extra done", extra, 0);
        end
    endtask

    task automatic t_hold;
        int lat;
        int pulses = 0;
        run_op(16'd40000, 16'd123, lat);
        dividend = 16'd1;
        divisor  = 16'd0;
        repeat (8) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check("R10 quotient held", longint'(quotient), 325);
        check("R10 flag held", longint'(div_zero), 0);
        check("R10 done low", pulses, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_latency();
        t_corners();
        t_zero();
        t_busy();
        t_hold();
        t_random();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule